// File: doc/BRIEF.md
# Microcode Bus Source Selector

This block produces the processor bus word for a single microinstruction. A 3-bit source code picks one of several producers: the register-file read port, memory data, a pointer-device input, a displacement built from the low bits of the macroinstruction register, or one of two task-owned inputs. The upper source codes are also gated with a word from an internal constant ROM, so the ROM word acts as a bit mask over that source. Two constant-select flags replace the selected source with the ROM word alone. Sources are combined by bitwise AND, so an idle contributor must present all ones.

A control-RAM readback path is timed from a registered flag. A read request in one cycle makes the readback word AND onto the bus in the following cycle only. One source code loads the register file. For that code the bus is forced to zero and a load-R strobe is raised, so that the next stage can finish the cycle with an ALU function of zero and T.

Top module: `ubus_source_sel`

## Requirements
- R1: With `src_sel` = 0, no constant flag set and no readback pending, `bus_word` equals `rf_data`.
- R2: With `src_sel` = 1 and no constant flag set, `bus_word` is all zeros (before any readback AND) and `load_r` is 1. In every other case `load_r` is 0.
- R3: With `src_sel` = 2, `bus_word` is all ones before any readback AND. Any code that is not decoded also yields all ones.
- R4: `src_sel` = 3 selects `task_a_data` and `src_sel` = 4 selects `task_b_data`.
- R5: For `src_sel` 5 (memory data), 6 (`mouse_data`) and 7 (displacement), the selected source is ANDed with the ROM word at address {`rsel_raw`, `src_sel`}. `rsel_raw` forms the upper 5 bits of that address.
- R6: The displacement word has `ir_disp_field`[7:0] in bits 7:0. When `ir_disp_field`[9:8] is 00 the upper byte is zero. Otherwise every bit of the upper byte copies `ir_disp_field`[7].
- R7: When `f1_const` or `f2_const` is 1, `bus_word` is the ROM word at {`rsel_raw`, `src_sel`} for any `src_sel`, with the readback AND still applied.
- R8: The ROM word at 8-bit address a has a in bits 7:0 and the bitwise inverse of a in bits 15:8.
- R9: A `rd_ram_req` sampled at a clock edge ANDs `ram_rdback` into `bus_word` for the following cycle only.
- R10: Reset clears the pending readback, so after reset the readback word has no effect until a new request is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Bus source code |
| rsel_raw | input | 5 | Unmodified register-select field, upper ROM address |
| f1_const | input | 1 | Constant select from the first function field |
| f2_const | input | 1 | Constant select from the second function field |
| rd_ram_req | input | 1 | Control-RAM read request, takes effect next cycle |
| rf_data | input | 16 | Register-file read data |
| md_data | input | 16 | Memory data |
| mouse_data | input | 16 | Pointer-device input bits |
| ir_disp_field | input | 10 | Low ten bits of the macroinstruction register |
| task_a_data | input | 16 | First task-specific source |
| task_b_data | input | 16 | Second task-specific source |
| ram_rdback | input | 16 | Control-RAM readback word |
| bus_word | output | 16 | Combined bus value |
| load_r | output | 1 | Register-file load strobe |

## Verification
The pending control-RAM readback can fall in the same cycle as a constant-masked source, a constant-only fetch or the load-R zero. In those cycles three factors meet in one AND. The bench provokes this by raising the read request at random during a full sweep of source code, register select and constant mode. Each cycle is judged against a model that carries the previous request forward and ANDs source, ROM mask and readback. A dedicated pulse confirms that the readback affects one cycle only and is gone after a reset.

// File: rtl/ubus_source_sel.sv
module ubus_source_sel #(
  parameter int W        = 16,
  parameter int RSEL_W   = 5,
  parameter int SRC_W    = 3,
  parameter int DISP_W   = 8,
  parameter int MASK_MIN = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SRC_W-1:0]    src_sel,
  input  logic [RSEL_W-1:0]   rsel_raw,
  input  logic                f1_const,
  input  logic                f2_const,
  input  logic                rd_ram_req,
  input  logic [W-1:0]        rf_data,
  input  logic [W-1:0]        md_data,
  input  logic [W-1:0]        mouse_data,
  input  logic [DISP_W+1:0]   ir_disp_field,
  input  logic [W-1:0]        task_a_data,
  input  logic [W-1:0]        task_b_data,
  input  logic [W-1:0]        ram_rdback,
  output logic [W-1:0]        bus_word,
  output logic                load_r
);

  localparam int ROM_AW = RSEL_W + SRC_W;
  localparam int ROM_N  = 1 << ROM_AW;

  localparam logic [SRC_W-1:0] SRC_RF    = SRC_W'(0);
  localparam logic [SRC_W-1:0] SRC_LOADR = SRC_W'(1);
  localparam logic [SRC_W-1:0] SRC_NONE  = SRC_W'(2);
  localparam logic [SRC_W-1:0] SRC_TSKA  = SRC_W'(3);
  localparam logic [SRC_W-1:0] SRC_TSKB  = SRC_W'(4);
  localparam logic [SRC_W-1:0] SRC_MD    = SRC_W'(5);
  localparam logic [SRC_W-1:0] SRC_MOUSE = SRC_W'(6);
  localparam logic [SRC_W-1:0] SRC_DISP  = SRC_W'(7);

  function automatic logic [W-1:0] rom_init(input int a);
    logic [W-1:0] w;
    logic [ROM_AW-1:0] ad;
    ad = ROM_AW'(a);
    for (int b = 0; b < W; b++)
      w[b] = (b < ROM_AW) ? ad[b] : ~ad[(b - ROM_AW) % ROM_AW];
    return w;
  endfunction

  logic [W-1:0] rom [ROM_N];

  genvar gi;
  generate
    for (gi = 0; gi < ROM_N; gi++) begin : g_rom
      assign rom[gi] = rom_init(gi);
    end
  endgenerate

  logic              rd_pend;
  logic              const_sel;
  logic              mask_gate;
  logic [W-1:0]      disp_word;
  logic [W-1:0]      src_word;
  logic [W-1:0]      rom_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend <= 1'b0;
    else        rd_pend <= rd_ram_req;
  end

  assign const_sel = f1_const | f2_const;
  assign mask_gate = const_sel | (src_sel >= SRC_W'(MASK_MIN));
  assign rom_word  = rom[{rsel_raw, src_sel}];

  assign disp_word = {{(W-DISP_W){(|ir_disp_field[DISP_W+1:DISP_W]) & ir_disp_field[DISP_W-1]}},
                      ir_disp_field[DISP_W-1:0]};

  always_comb begin
    unique case (src_sel)
      SRC_RF:    src_word = rf_data;
      SRC_LOADR: src_word = '0;
      SRC_NONE:  src_word = '1;
      SRC_TSKA:  src_word = task_a_data;
      SRC_TSKB:  src_word = task_b_data;
      SRC_MD:    src_word = md_data;
      SRC_MOUSE: src_word = mouse_data;
      SRC_DISP:  src_word = disp_word;
      default:   src_word = '1;
    endcase
  end

  assign bus_word = (const_sel ? '1 : src_word)
                  & (mask_gate ? rom_word : '1)
                  & (rd_pend ? ram_rdback : '1);

  assign load_r = ~const_sel & (src_sel == SRC_LOADR);

endmodule

// File: rtl/ubus_source_sel_chk.sv
module ubus_source_sel_chk #(
  parameter int W      = 16,
  parameter int SRC_W  = 3,
  parameter int DISP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_W-1:0]  src_sel,
  input logic              f1_const,
  input logic              f2_const,
  input logic              rd_ram_req,
  input logic [W-1:0]      md_data,
  input logic [DISP_W+1:0] ir_disp_field,
  input logic [W-1:0]      ram_rdback,
  input logic [W-1:0]      bus_word,
  input logic              load_r
);

  // R2
  load_r_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_r |-> (bus_word == '0) && (src_sel == SRC_W'(1)) && !f1_const && !f2_const);

  // R3
  none_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_W'(2)) && !f1_const && !f2_const && !($past(rst_n) && $past(rd_ram_req))
      |-> bus_word == '1);

  // R9
  rdback_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(rd_ram_req) |-> (bus_word & ~ram_rdback) == '0);

  // R5
  md_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_W'(5)) && !f1_const && !f2_const |-> (bus_word & ~md_data) == '0);

  // R6
  disp_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_W'(7)) && !f1_const && !f2_const && (ir_disp_field[DISP_W+1:DISP_W] == 2'b00)
      |-> bus_word[W-1:DISP_W] == '0);

endmodule

bind ubus_source_sel ubus_source_sel_chk #(.W(W), .SRC_W(SRC_W), .DISP_W(DISP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .f1_const(f1_const), .f2_const(f2_const),
  .rd_ram_req(rd_ram_req), .md_data(md_data), .ir_disp_field(ir_disp_field),
  .ram_rdback(ram_rdback), .bus_word(bus_word), .load_r(load_r)
);

// File: tb/tb_ubus_source_sel.sv
`timescale 1ns/1ps
module tb_ubus_source_sel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_sel = '0;
  logic [4:0]  rsel_raw = '0;
  logic        f1_const = 1'b0, f2_const = 1'b0, rd_ram_req = 1'b0;
  logic [15:0] rf_data = '0, md_data = '0, mouse_data = '0;
  logic [9:0]  ir_disp_field = '0;
  logic [15:0] task_a_data = '0, task_b_data = '0, ram_rdback = '0;
  logic [15:0] bus_word;
  logic        load_r;

  int n_chk = 0, n_bad = 0;
  logic prev_req = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  ubus_source_sel dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .rsel_raw(rsel_raw),
    .f1_const(f1_const), .f2_const(f2_const), .rd_ram_req(rd_ram_req),
    .rf_data(rf_data), .md_data(md_data), .mouse_data(mouse_data),
    .ir_disp_field(ir_disp_field), .task_a_data(task_a_data), .task_b_data(task_b_data),
    .ram_rdback(ram_rdback), .bus_word(bus_word), .load_r(load_r)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [15:0] rom_exp(input logic [7:0] a);
    return {~a, a};
  endfunction

  function automatic logic [15:0] disp_exp(input logic [9:0] ir);
    if (ir[9:8] == 2'b00) return {8'h00, ir[7:0]};
    return {{8{ir[7]}}, ir[7:0]};
  endfunction

  function automatic logic [15:0] model(input logic pend);
    logic [15:0] s;
    logic [15:0] r;
    r = rom_exp({rsel_raw, src_sel});
    if (f1_const || f2_const) s = r;
    else case (src_sel)
      3'd0: s = rf_data;
      3'd1: s = 16'h0000;
      3'd2: s = 16'hFFFF;
      3'd3: s = task_a_data;
      3'd4: s = task_b_data;
      3'd5: s = md_data & r;
      3'd6: s = mouse_data & r;
      default: s = disp_exp(ir_disp_field) & r;
    endcase
    if (pend) s = s & ram_rdback;
    return s;
  endfunction

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (src=%0d rsel=%0d f1=%b f2=%b)",
               req, act, exp, src_sel, rsel_raw, f1_const, f2_const);
    end
  endtask

  task automatic rand_data();
    rng = nxt(rng); rf_data = rng[15:0]; md_data = rng[31:16];
    rng = nxt(rng); mouse_data = rng[15:0]; task_a_data = rng[31:16];
    rng = nxt(rng); task_b_data = rng[15:0]; ram_rdback = rng[31:16];
    rng = nxt(rng); ir_disp_field = rng[9:0];
  endtask

  function automatic string tag_for(input logic [2:0] s, input logic c);
    if (c) return "R7/R8";
    case (s)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      3'd7: return "R6/R5";
      default: return "R5/R8";
    endcase
  endfunction

  task automatic step(input logic req, input string tag);
    @(negedge clk);
    rd_ram_req = req;
    #1;
    chk16(prev_req ? {tag, "+R9"} : tag, bus_word, model(prev_req));
    chk16("R2 load_r", {15'd0, load_r},
          {15'd0, (src_sel == 3'd1) && !f1_const && !f2_const});
    prev_req = req;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    src_sel = 3'd2;
    ram_rdback = 16'h0F0F;
    rd_ram_req = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset holds pending clear despite request
    chk16("R10 reset", bus_word, 16'hFFFF);
    chk16("R2 reset load_r", {15'd0, load_r}, 16'd0);
    rd_ram_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    prev_req = 1'b0;

    // Full sweep: source code x rsel x constant mode, random readback requests
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 8; s++)
        for (int r = 0; r < 32; r++) begin
          src_sel = 3'(s); rsel_raw = 5'(r);
          f1_const = (m == 1); f2_const = (m == 2);
          rand_data();
          rng = nxt(rng);
          step(rng[3], tag_for(3'(s), m != 0));
        end

    // R6: displacement sweep over every X-field and sign combination
    f1_const = 1'b0; f2_const = 1'b0; src_sel = 3'd7;
    for (int i = 0; i < 1024; i += 3) begin
      rand_data();
      ir_disp_field = 10'(i);
      rsel_raw = 5'(i >> 5);
      step(1'b0, "R6");
    end

    // R9: a single request affects exactly one following cycle
    src_sel = 3'd2; ram_rdback = 16'h3C5A;
    step(1'b1, "R9 pre");
    @(negedge clk); rd_ram_req = 1'b0; #1;
    chk16("R9 one cycle", bus_word, 16'h3C5A);
    @(negedge clk); #1;
    chk16("R9 cleared", bus_word, 16'hFFFF);
    prev_req = 1'b0;

    // R10: reset mid-run drops a pending readback
    @(negedge clk); rd_ram_req = 1'b1;
    @(negedge clk); rd_ram_req = 1'b0; rst_n = 1'b0; #1;
    chk16("R10 async clear", bus_word, 16'hFFFF);
    @(negedge clk); rst_n = 1'b1; prev_req = 1'b0;
    step(1'b0, "R10 after");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule